// File: doc/BRIEF.md
# Arithmetic Flag and Decimal-Adjust Unit

This block takes an arithmetic request (an 8-bit or 16-bit add or subtract, with or without the incoming carry, or a decimal adjust of the accumulator) and forms the result together with the negative, zero, overflow, half-carry and carry flags. The adder is built in. Result and flags are registered, and they update on the clock edge that samples a valid request. Flags that an operation does not affect keep their registered value.

Byte operations use the low byte of each operand. Word operations treat operand A as the accumulator pair, high byte first, and return the full 16-bit pair. Overflow comes from one exclusive-or expression: the two operands, the result, and the result shifted right by one, taken at the top data bit. This single form covers both add and subtract. The decimal adjust applies a low-nibble and a high-nibble correction to a binary sum, using the half-carry and carry flags supplied with the request.

Top module: `alu_flag_unit`

## Requirements
- R1: While rst_ni is low, and after its release until the first accepted request, res_o and all five flag outputs are zero.
- R2: op_i codes are ADD8=0, ADC8=1, SUB8=2, SBC8=3, ADD16=4, SUB16=5, DAA=6. For the byte codes, res_o[7:0] is opa_i[7:0] plus or minus opb_i[7:0]. ADC8 adds c_i, and SBC8 subtracts c_i. c_o is the carry out of bit 7 for additions and the borrow out of bit 7 for subtractions.
- R3: For byte operations, v_o equals bit 7 of (a ^ b ^ r ^ (r >> 1)), where r is the 9-bit result including its carry or borrow bit. This equals signed two's-complement overflow.
- R4: ADD8 and ADC8 set h_o to bit 4 of (a ^ b ^ r), which is the carry out of the low nibble. SUB8 and SBC8 leave h_o unchanged.
- R5: For byte operations and DAA, res_o[15:8] is zero, n_o is res_o[7], and z_o is set exactly when the 8-bit result is zero.
- R6: ADD16 and SUB16 form the 16-bit sum or difference of opa_i and opb_i with no incoming carry. n_o is bit 15 and z_o marks an all-zero result. v_o is bit 15 of the same exclusive-or expression on the 17-bit result. c_o is the carry or borrow out of bit 15. h_o is unchanged.
- R7: DAA adds 0x06 to opa_i[7:0] when its low nibble is above 9 or h_i is set.
- R8: DAA adds 0x60 when the high nibble is above 9, or c_i is set, or the high nibble is above 8 while the low nibble is above 9. The result is truncated to 8 bits. c_o becomes the high-correction condition OR c_i. v_o and h_o are unchanged.
- R9: Outputs change only on the clock edge that samples valid_i high. The new values are visible one cycle after the request. With valid_i low, all outputs hold.
- R10: op_i code 7 is ignored: all outputs hold even when valid_i is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| opa_i | input | 16 | Operand A (byte ops use [7:0]; word ops use the accumulator pair) |
| opb_i | input | 16 | Operand B |
| h_i | input | 1 | Current half-carry flag, used by DAA |
| c_i | input | 1 | Current carry flag, used by ADC8, SBC8 and DAA |
| res_o | output | 16 | Registered result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| h_o | output | 1 | Half-carry flag |
| c_o | output | 1 | Carry or borrow flag |

## Verification
Every output is registered directly from combinational logic. A wrong carry-in selection, a wrong overflow tap or a missed decimal correction therefore shows up on res_o or a flag in the cycle right after the request that triggers it. The only state that outlives a request is the held H and V flags. A write-enable fault on them stays hidden until the next request that is meant to leave them alone, and then it shows up one cycle later as a changed h_o or v_o. Byte arithmetic and the decimal adjust are swept over every accumulator value and flag combination, so each of these faults is caught near where it first occurs.

// File: rtl/afu_pkg.sv
package afu_pkg;
  localparam int AFU_BYTE_W = 8;
  localparam int AFU_NIB_W  = 4;

  typedef enum logic [2:0] {
    OP_ADD8  = 3'd0,
    OP_ADC8  = 3'd1,
    OP_SUB8  = 3'd2,
    OP_SBC8  = 3'd3,
    OP_ADD16 = 3'd4,
    OP_SUB16 = 3'd5,
    OP_DAA   = 3'd6,
    OP_RSVD  = 3'd7
  } afu_op_e;
endpackage

// File: rtl/afu_arith.sv
module afu_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] r_o,
  output logic         v_o,
  output logic         h_o,
  output logic         c_o
);
  localparam int HB = (W > 4) ? 4 : W - 1;

  logic [W:0]   r_ext;
  logic [W-1:0] x_bits;

  always_comb begin
    if (sub_i) r_ext = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
    else       r_ext = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  end

  assign x_bits = a_i ^ b_i ^ r_ext[W-1:0];
  assign r_o    = r_ext[W-1:0];
  // top bit of a^b^r^(r>>1): carry into msb xor carry out
  assign v_o    = x_bits[W-1] ^ r_ext[W];
  assign h_o    = x_bits[HB];
  assign c_o    = r_ext[W];
endmodule

// File: rtl/afu_decadj.sv
module afu_decadj #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         h_i,
  input  logic         c_i,
  output logic [W-1:0] r_o,
  output logic         c_o
);
  localparam int NW = W / 2;
  localparam logic [NW-1:0] LIM9 = NW'(9);
  localparam logic [NW-1:0] LIM8 = NW'(8);
  localparam logic [W-1:0]  LO_FIX = W'(6);
  localparam logic [W-1:0]  HI_FIX = W'(6) << NW;

  logic [NW-1:0] lo_nib, hi_nib;
  logic          lo_big, fix_lo, fix_hi;

  assign lo_nib = a_i[NW-1:0];
  assign hi_nib = a_i[W-1:NW];
  assign lo_big = lo_nib > LIM9;
  assign fix_lo = lo_big || h_i;
  assign fix_hi = (hi_nib > LIM9) || c_i || ((hi_nib > LIM8) && lo_big);

  assign r_o = a_i + (fix_lo ? LO_FIX : '0) + (fix_hi ? HI_FIX : '0);
  assign c_o = fix_hi || c_i;
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import afu_pkg::*;
#(
  parameter int BYTE_W = AFU_BYTE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [2:0]          op_i,
  input  logic [2*BYTE_W-1:0] opa_i,
  input  logic [2*BYTE_W-1:0] opb_i,
  input  logic                h_i,
  input  logic                c_i,
  output logic [2*BYTE_W-1:0] res_o,
  output logic                n_o,
  output logic                z_o,
  output logic                v_o,
  output logic                h_o,
  output logic                c_o
);
  localparam int WORD_W = 2 * BYTE_W;

  afu_op_e op;
  assign op = afu_op_e'(op_i);

  logic is_word, is_daa, is_badd, take;
  assign is_word = (op == OP_ADD16) || (op == OP_SUB16);
  assign is_daa  = (op == OP_DAA);
  assign is_badd = (op == OP_ADD8) || (op == OP_ADC8);
  assign take    = valid_i && (op != OP_RSVD);

  // byte path
  logic [BYTE_W-1:0] b_r;
  logic b_v, b_h, b_c, b_sub, b_cin;
  assign b_sub = (op == OP_SUB8) || (op == OP_SBC8);
  assign b_cin = ((op == OP_ADC8) || (op == OP_SBC8)) ? c_i : 1'b0;

  afu_arith #(.W(BYTE_W)) u_byte (
    .a_i(opa_i[BYTE_W-1:0]), .b_i(opb_i[BYTE_W-1:0]),
    .cin_i(b_cin), .sub_i(b_sub),
    .r_o(b_r), .v_o(b_v), .h_o(b_h), .c_o(b_c)
  );

  // word path
  logic [WORD_W-1:0] w_r;
  logic w_v, w_h, w_c;

  afu_arith #(.W(WORD_W)) u_word (
    .a_i(opa_i), .b_i(opb_i),
    .cin_i(1'b0), .sub_i(op == OP_SUB16),
    .r_o(w_r), .v_o(w_v), .h_o(w_h), .c_o(w_c)
  );

  // decimal adjust
  logic [BYTE_W-1:0] d_r;
  logic d_c;

  afu_decadj #(.W(BYTE_W)) u_daa (
    .a_i(opa_i[BYTE_W-1:0]), .h_i(h_i), .c_i(c_i),
    .r_o(d_r), .c_o(d_c)
  );

  logic [WORD_W-1:0] nxt_res;
  logic nxt_c, nxt_v;

  always_comb begin
    if (is_word) begin
      nxt_res = w_r;
      nxt_c   = w_c;
      nxt_v   = w_v;
    end else if (is_daa) begin
      nxt_res = {{BYTE_W{1'b0}}, d_r};
      nxt_c   = d_c;
      nxt_v   = v_o;
    end else begin
      nxt_res = {{BYTE_W{1'b0}}, b_r};
      nxt_c   = b_c;
      nxt_v   = b_v;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      n_o   <= 1'b0;
      z_o   <= 1'b0;
      v_o   <= 1'b0;
      h_o   <= 1'b0;
      c_o   <= 1'b0;
    end else if (take) begin
      res_o <= nxt_res;
      n_o   <= is_word ? nxt_res[WORD_W-1] : nxt_res[BYTE_W-1];
      z_o   <= (nxt_res == '0);
      v_o   <= nxt_v;
      c_o   <= nxt_c;
      if (is_badd) h_o <= b_h;
    end
  end

  logic unused_w_h;
  assign unused_w_h = w_h;
endmodule

// File: rtl/afu_checker.sv
module afu_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [2:0]  op_i,
  input logic        c_i,
  input logic [15:0] res_o,
  input logic        n_o,
  input logic        z_o,
  input logic        v_o,
  input logic        h_o,
  input logic        c_o
);
  p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable({res_o, n_o, z_o, v_o, h_o, c_o}));

  p_reserved_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd7) |=> $stable({res_o, n_o, z_o, v_o, h_o, c_o}));

  p_sub_h_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 3'd2 || op_i == 3'd3)) |=> $stable(h_o));

  p_word_h_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 3'd4 || op_i == 3'd5)) |=> $stable(h_o));

  p_daa_vh_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd6) |=> $stable({v_o, h_o}));

  p_daa_carry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd6 && c_i) |=> c_o);

  p_byte_upper_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i < 3'd4 || op_i == 3'd6)) |=> (res_o[15:8] == 8'h00));

  p_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_o |-> (res_o == 16'h0000));

  always_comb begin
    if (!rst_ni) p_reset_r1: assert ({res_o, n_o, z_o, v_o, h_o, c_o} == '0);
  end
endmodule

bind alu_flag_unit afu_checker u_chk (.*);

// File: tb/sim_alu_flag_unit.sv
module sim_alu_flag_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [2:0] op = '0;
  logic [15:0] opa = '0, opb = '0;
  logic hin = 1'b0, cin = 1'b0;
  logic [15:0] res;
  logic n, z, v, h, c;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit exp_v = 1'b0, exp_h = 1'b0;
  logic [15:0] exp_r = '0;
  bit exp_n = 1'b0, exp_z = 1'b0, exp_c = 1'b0;

  always #10 clk = ~clk;

  alu_flag_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .opa_i(opa), .opb_i(opb), .h_i(hin), .c_i(cin),
    .res_o(res), .n_o(n), .z_o(z), .v_o(v), .h_o(h), .c_o(c)
  );

  function automatic int sx(input int x, input int w);
    return (x >= (1 << (w - 1))) ? x - (1 << w) : x;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if ({res, n, z, v, h, c} !== {exp_r, exp_n, exp_z, exp_v, exp_h, exp_c}) begin
      fails++;
      $display("FAIL %s: res=%h nzvhc=%b%b%b%b%b expected res=%h nzvhc=%b%b%b%b%b",
               tag, res, n, z, v, h, c, exp_r, exp_n, exp_z, exp_v, exp_h, exp_c);
    end
  endtask

  task automatic run(input bit vld, input int o, input int a, input int b,
                     input bit hf, input bit cf, input string tag);
    int s, ci, w, lo, hi, add;
    bit chi;
    if (vld && o != 7) begin
      w = (o == 4 || o == 5) ? 16 : 8;
      ci = (o == 1 || o == 3) ? int'(cf) : 0;
      if (o == 6) begin
        lo = a & 15; hi = (a >> 4) & 15; add = 0;
        if (lo > 9 || hf) add += 6;
        chi = (hi > 9) || cf || (hi > 8 && lo > 9);
        if (chi) add += 'h60;
        s = (a + add) & 255;
        exp_c = chi || cf;
      end else if (o == 0 || o == 1 || o == 4) begin
        s = (a & ((1 << w) - 1)) + (b & ((1 << w) - 1)) + ci;
        exp_c = s >= (1 << w);
        s = sx(a & ((1 << w) - 1), w) + sx(b & ((1 << w) - 1), w) + ci;
        exp_v = (s > (1 << (w - 1)) - 1) || (s < -(1 << (w - 1)));
        if (w == 8) exp_h = ((a & 15) + (b & 15) + ci) > 15;
        s = ((a & ((1 << w) - 1)) + (b & ((1 << w) - 1)) + ci) & ((1 << w) - 1);
      end else begin
        s = (a & ((1 << w) - 1)) - (b & ((1 << w) - 1)) - ci;
        exp_c = s < 0;
        s = sx(a & ((1 << w) - 1), w) - sx(b & ((1 << w) - 1), w) - ci;
        exp_v = (s > (1 << (w - 1)) - 1) || (s < -(1 << (w - 1)));
        s = ((a & ((1 << w) - 1)) - (b & ((1 << w) - 1)) - ci) & ((1 << w) - 1);
      end
      exp_r = 16'(s);
      exp_n = (w == 16) ? exp_r[15] : exp_r[7];
      exp_z = (s == 0);
    end
    valid = vld; op = 3'(o); opa = 16'(a); opb = 16'(b); hin = hf; cin = cf;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h1234_5678;
    #5;
    checks++;  // R1 while reset is held
    if ({res, n, z, v, h, c} !== '0) begin
      fails++; $display("FAIL R1: outputs=%h expected 0", {res, n, z, v, h, c});
    end
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2 R3 R4 R5 byte sweep
    for (int o = 0; o < 4; o++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 5)
          run(1'b1, o, a, b, 1'b0, ((a ^ b) & 1) != 0, "R2 R3 R4 R5");
    run(1'b1, 0, 'h7f, 'h01, 0, 0, "R3");
    run(1'b1, 2, 'h80, 'h01, 0, 0, "R3");
    run(1'b1, 3, 'h00, 'hff, 0, 1, "R2");
    run(1'b1, 1, 'hff, 'h00, 0, 1, "R5");

    // R7 R8 decimal adjust, all A and flag pairs
    for (int a = 0; a < 256; a++)
      for (int f = 0; f < 4; f++)
        run(1'b1, 6, a, 0, f[0], f[1], "R7 R8");

    // R6 word ops
    run(1'b1, 4, 'h7fff, 'h0001, 0, 0, "R6");
    run(1'b1, 4, 'hffff, 'h0001, 0, 1, "R6");
    run(1'b1, 5, 'h8000, 'h0001, 0, 0, "R6");
    run(1'b1, 5, 'h0000, 'h0001, 0, 0, "R6");
    run(1'b1, 5, 'h1234, 'h1234, 0, 0, "R6");
    for (int i = 0; i < 3000; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      run(1'b1, 4 + (i & 1), int'(seed[31:16]), int'(seed[15:0] ^ seed[29:14]),
          seed[3], seed[5], "R6");
    end

    // R4 hold across subtract, R8 hold of V/H across DAA
    run(1'b1, 0, 'h0f, 'h01, 0, 0, "R4");
    run(1'b1, 2, 'h00, 'h01, 0, 0, "R4");
    run(1'b1, 0, 'h7f, 'h01, 0, 0, "R8");
    run(1'b1, 6, 'h00, 0, 0, 0, "R8");

    // R9 idle hold, R10 reserved code
    run(1'b1, 0, 'h12, 'h34, 0, 0, "R9");
    for (int i = 0; i < 8; i++) run(1'b0, i, 'hff, 'hff, 1, 1, "R9");
    for (int i = 0; i < 8; i++) run(1'b1, 7, i * 37, 'hff, 1, 1, "R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule